// File: doc/BRIEF.md
# Interrupt-Driven Single-Transfer Engine

This block stands in for a short interrupt handler. An interrupt source that has been given a channel does not start a software routine. The engine moves one datum between two memory addresses. Eight channels each hold their own setup:

- a source pointer and a destination pointer;
- a transfer counter;
- a size bit, which selects a byte or a 16-bit word;
- a step-select bit, which says which of the two pointers advances after a move.

Priority logic outside the block picks the winning channel and presents its index on a valid/ready trigger stream. For each accepted trigger the engine does one of three things:

- It makes one read and one write on a request/grant memory port, then steps one pointer and updates the counter.
- When the counter is already exhausted, it forwards a normal interrupt request for that channel.
- When a word move would touch an odd address, it reports an error and moves nothing.

Every accepted trigger ends in exactly one one-cycle pulse, tagged with the channel index: completion, interrupt or error. A reference model can follow memory contents from these pulses.

The trigger stream obeys valid/ready back-pressure:
- `trig_ready` is high only while the engine is idle.
- A trigger is taken on a clock edge where both `trig_valid` and `trig_ready` are high.
- The source must hold `trig_valid` and `trig_chan` steady until that edge.

The memory port works as follows:
- The engine holds `mem_req` and its address, size and data steady until `mem_gnt` is sampled high at a clock edge.
- For a read, the memory returns `mem_rdata` in the same cycle as the grant.

Top module: `evt_mover`

## Requirements
- R1: After reset, `trig_ready` is 1, `mem_req`, `done_valid`, `irq_valid` and `err_valid` are 0, and every channel counter is 0.
- R2: Suppose a trigger is accepted on a channel whose counter is nonzero, and the move is not misaligned. The engine reads at the source pointer, then writes the same datum at the destination pointer. A byte uses bits [7:0] of the data buses. A word uses all 16 bits, with the even address in bits [7:0].
- R3: After a completed move, exactly one pointer advances. When `step_dst`=1 it is the destination; when `step_dst`=0 it is the source. The pointer advances by 1 for a byte (`word`=0) and by 2 for a word (`word`=1).
- R4: Each completed move decrements the counter by 1. A counter of 0xFF is continuous mode and is never decremented.
- R5: A trigger on a channel whose counter is 0 produces an `irq_valid` pulse carrying that channel. It makes no memory request and changes no channel state.
- R6: A word trigger with an odd source or destination pointer produces an `err_valid` pulse. It makes no memory request and leaves the channel's pointers and counter unchanged.
- R7: Each accepted trigger yields exactly one one-cycle pulse on `done_valid`, `irq_valid` or `err_valid`, with `evt_chan` equal to the channel index. `done_valid` is high in the cycle after the write grant.
- R8: `trig_ready` is 0 from the cycle after an accepted trigger until the cycle of that trigger's outcome pulse.
- R9: While `mem_req` is 1 and `mem_gnt` is 0, `mem_req`, `mem_we`, `mem_word` and `mem_addr` hold their values into the next cycle.
- R10: A configuration write to a channel in the same cycle as that channel's end-of-move update takes precedence. The channel then holds exactly the written pointers and counter.
- R11: Servicing one channel leaves the setup of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the setup of channel `cfg_chan` |
| cfg_chan | input | 3 | Channel being configured |
| cfg_src | input | 24 | Source pointer to load |
| cfg_dst | input | 24 | Destination pointer to load |
| cfg_cnt | input | 8 | Counter to load (0xFF = continuous) |
| cfg_word | input | 1 | 1 = 16-bit word, 0 = byte |
| cfg_step_dst | input | 1 | 1 = destination advances, 0 = source advances |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | Engine idle, trigger can be taken |
| trig_chan | input | 3 | Channel chosen by priority logic |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant; completes the access at this edge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 16-bit access, 0 = byte |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with the read grant |
| done_valid | output | 1 | One move completed |
| irq_valid | output | 1 | Counter exhausted; interrupt forwarded |
| err_valid | output | 1 | Misaligned word move refused |
| evt_chan | output | 3 | Channel of the current outcome pulse |

## Verification
Two functions can fall in the same clock edge: the end-of-move update of a channel's pointers and counter, and a configuration write to that same channel. The bench provokes this with zero-wait grants. It waits for the cycle in which the write request is pending and the grant is certain, then drives `cfg_we` for the serviced channel in exactly that cycle. It judges the outcome with two follow-up triggers. The first must copy the datum between the newly written, unstepped addresses. The second must end as an interrupt, because the written counter of 1 has then run out.

// File: rtl/evt_mover_pkg.sv
package evt_mover_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/evt_mover_step.sv
module evt_mover_step #(
  parameter int AW         = 24,
  parameter int CW         = 8,
  parameter int WORD_BYTES = 2
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic          word,
  input  logic          step_dst,
  output logic [AW-1:0] nxt_src,
  output logic [AW-1:0] nxt_dst,
  output logic [CW-1:0] nxt_cnt,
  output logic          cnt_zero,
  output logic          misalign
);
  localparam logic [CW-1:0] CONT_CNT = {CW{1'b1}};
  logic [AW-1:0] step;

  always_comb begin
    step     = word ? AW'(WORD_BYTES) : AW'(1);
    nxt_src  = step_dst ? src : src + step;
    nxt_dst  = step_dst ? dst + step : dst;
    nxt_cnt  = (cnt == CONT_CNT) ? cnt : cnt - CW'(1);
    cnt_zero = (cnt == '0);
    misalign = word && (src[0] || dst[0]);
  end
endmodule

// File: rtl/evt_mover_chan_bank.sv
module evt_mover_chan_bank #(
  parameter int NUM_CH = 8,
  parameter int AW     = 24,
  parameter int CW     = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic [AW-1:0]   cfg_src,
  input  logic [AW-1:0]   cfg_dst,
  input  logic [CW-1:0]   cfg_cnt,
  input  logic            cfg_word,
  input  logic            cfg_step_dst,
  input  logic            upd_en,
  input  logic [CH_W-1:0] upd_chan,
  input  logic [AW-1:0]   upd_src,
  input  logic [AW-1:0]   upd_dst,
  input  logic [CW-1:0]   upd_cnt,
  input  logic [CH_W-1:0] rd_chan,
  output logic [AW-1:0]   rd_src,
  output logic [AW-1:0]   rd_dst,
  output logic [CW-1:0]   rd_cnt,
  output logic            rd_word,
  output logic            rd_step_dst
);
  logic [AW-1:0] src_q   [NUM_CH];
  logic [AW-1:0] dst_q   [NUM_CH];
  logic [CW-1:0] cnt_q   [NUM_CH];
  logic          word_q  [NUM_CH];
  logic          stepd_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic cfg_hit, upd_hit;
    assign cfg_hit = cfg_we && (cfg_chan == CH_W'(g));
    assign upd_hit = upd_en && (upd_chan == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[g]   <= '0;
        dst_q[g]   <= '0;
        cnt_q[g]   <= '0;
        word_q[g]  <= 1'b0;
        stepd_q[g] <= 1'b0;
      end else if (cfg_hit) begin
        src_q[g]   <= cfg_src;
        dst_q[g]   <= cfg_dst;
        cnt_q[g]   <= cfg_cnt;
        word_q[g]  <= cfg_word;
        stepd_q[g] <= cfg_step_dst;
      end else if (upd_hit) begin
        src_q[g] <= upd_src;
        dst_q[g] <= upd_dst;
        cnt_q[g] <= upd_cnt;
      end
    end
  end

  assign rd_src      = src_q[rd_chan];
  assign rd_dst      = dst_q[rd_chan];
  assign rd_cnt      = cnt_q[rd_chan];
  assign rd_word     = word_q[rd_chan];
  assign rd_step_dst = stepd_q[rd_chan];

  // R10: configuration beats the end-of-move update on a shared channel
  a_r10_cfg_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && upd_en && cfg_chan == upd_chan)
      |=> (src_q[$past(cfg_chan)] == $past(cfg_src)) &&
          (cnt_q[$past(cfg_chan)] == $past(cfg_cnt)));
endmodule

// File: rtl/evt_mover_seq.sv
module evt_mover_seq
  import evt_mover_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_valid,
  input  logic [CH_W-1:0] trig_chan,
  output logic            trig_ready,
  output logic [CH_W-1:0] rd_chan,
  input  logic [AW-1:0]   rd_src,
  input  logic [AW-1:0]   rd_dst,
  input  logic [CW-1:0]   rd_cnt,
  input  logic            rd_word,
  input  logic            rd_step_dst,
  output logic            upd_en,
  output logic [CH_W-1:0] upd_chan,
  output logic [AW-1:0]   upd_src,
  output logic [AW-1:0]   upd_dst,
  output logic [CW-1:0]   upd_cnt,
  output logic            mem_req,
  input  logic            mem_gnt,
  output logic            mem_we,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done_valid,
  output logic            irq_valid,
  output logic            err_valid,
  output logic [CH_W-1:0] evt_chan
);
  localparam int BW = DW / 2;

  seq_state_t      state_q;
  logic [CH_W-1:0] s_chan;
  logic [AW-1:0]   s_src, s_dst;
  logic [CW-1:0]   s_cnt;
  logic            s_word, s_step_dst;
  logic [DW-1:0]   data_q;
  logic [AW-1:0]   nxt_src, nxt_dst;
  logic [CW-1:0]   nxt_cnt;
  logic            cnt_zero, misalign;
  logic            accept;

  evt_mover_step #(.AW(AW), .CW(CW), .WORD_BYTES(DW / 8)) step_i (
    .src(s_src), .dst(s_dst), .cnt(s_cnt), .word(s_word), .step_dst(s_step_dst),
    .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_cnt(nxt_cnt),
    .cnt_zero(cnt_zero), .misalign(misalign)
  );

  assign trig_ready = (state_q == ST_IDLE);
  assign accept     = trig_valid && trig_ready;
  assign rd_chan    = trig_chan;

  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_word  = s_word;
  assign mem_addr  = (state_q == ST_WRITE) ? s_dst : s_src;
  assign mem_wdata = s_word ? data_q : {{(DW-BW){1'b0}}, data_q[BW-1:0]};

  assign upd_en   = (state_q == ST_WRITE) && mem_gnt;
  assign upd_chan = s_chan;
  assign upd_src  = nxt_src;
  assign upd_dst  = nxt_dst;
  assign upd_cnt  = nxt_cnt;
  assign evt_chan = s_chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      s_chan     <= '0;
      s_src      <= '0;
      s_dst      <= '0;
      s_cnt      <= '0;
      s_word     <= 1'b0;
      s_step_dst <= 1'b0;
      data_q     <= '0;
      done_valid <= 1'b0;
      irq_valid  <= 1'b0;
      err_valid  <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      irq_valid  <= 1'b0;
      err_valid  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          s_chan     <= trig_chan;
          s_src      <= rd_src;
          s_dst      <= rd_dst;
          s_cnt      <= rd_cnt;
          s_word     <= rd_word;
          s_step_dst <= rd_step_dst;
          state_q    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (cnt_zero) begin
            irq_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (misalign) begin
            err_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_READ: if (mem_gnt) begin
          data_q  <= mem_rdata;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (mem_gnt) begin
          done_valid <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a pending request keeps its attributes until granted
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_we) && $stable(mem_word) && $stable(mem_addr));

  // R7: at most one outcome pulse at a time
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_valid, irq_valid, err_valid}));

  // R8: an accepted trigger closes the stream in the next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready) |=> !trig_ready);
endmodule

// File: rtl/evt_mover.sv
module evt_mover #(
  parameter int NUM_CH = 8,
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int CW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CH)-1:0] cfg_chan,
  input  logic [AW-1:0]             cfg_src,
  input  logic [AW-1:0]             cfg_dst,
  input  logic [CW-1:0]             cfg_cnt,
  input  logic                      cfg_word,
  input  logic                      cfg_step_dst,
  input  logic                      trig_valid,
  output logic                      trig_ready,
  input  logic [$clog2(NUM_CH)-1:0] trig_chan,
  output logic                      mem_req,
  input  logic                      mem_gnt,
  output logic                      mem_we,
  output logic                      mem_word,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  input  logic [DW-1:0]             mem_rdata,
  output logic                      done_valid,
  output logic                      irq_valid,
  output logic                      err_valid,
  output logic [$clog2(NUM_CH)-1:0] evt_chan
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0] rd_chan, upd_chan;
  logic [AW-1:0]   rd_src, rd_dst, upd_src, upd_dst;
  logic [CW-1:0]   rd_cnt, upd_cnt;
  logic            rd_word, rd_step_dst, upd_en;

  evt_mover_chan_bank #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW), .CH_W(CH_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_cnt(cfg_cnt), .cfg_word(cfg_word), .cfg_step_dst(cfg_step_dst),
    .upd_en(upd_en), .upd_chan(upd_chan), .upd_src(upd_src), .upd_dst(upd_dst),
    .upd_cnt(upd_cnt), .rd_chan(rd_chan), .rd_src(rd_src), .rd_dst(rd_dst),
    .rd_cnt(rd_cnt), .rd_word(rd_word), .rd_step_dst(rd_step_dst)
  );

  evt_mover_seq #(.AW(AW), .DW(DW), .CW(CW), .CH_W(CH_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_chan(trig_chan), .trig_ready(trig_ready),
    .rd_chan(rd_chan), .rd_src(rd_src), .rd_dst(rd_dst), .rd_cnt(rd_cnt),
    .rd_word(rd_word), .rd_step_dst(rd_step_dst),
    .upd_en(upd_en), .upd_chan(upd_chan), .upd_src(upd_src), .upd_dst(upd_dst),
    .upd_cnt(upd_cnt),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .irq_valid(irq_valid), .err_valid(err_valid),
    .evt_chan(evt_chan)
  );

  // R5: a forwarded interrupt follows a cycle with no memory traffic
  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mem_req));

  // R6: a refused move follows a cycle with no memory traffic
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !$past(mem_req));

  // R7: completion is reported right after a granted write
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(mem_req && mem_we && mem_gnt));
endmodule

// File: tb/evt_mover_tb_top.sv
`timescale 1ns/1ps
module evt_mover_tb_top;
  localparam int NUM_CH = 8;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int NV = 8;
  // {chan[3], src[8], dst[8], cnt[8], word, step_dst, ntrig[3], wait[2]}
  localparam logic [33:0] VEC [NV] = '{
    {3'd0, 8'h10, 8'h80, 8'd3,   1'b0, 1'b0, 3'd4, 2'd0},
    {3'd1, 8'h20, 8'h90, 8'd2,   1'b1, 1'b1, 3'd3, 2'd1},
    {3'd2, 8'h31, 8'hA0, 8'd5,   1'b1, 1'b0, 3'd1, 2'd0},
    {3'd3, 8'h40, 8'hA5, 8'hFF,  1'b0, 1'b1, 3'd3, 2'd2},
    {3'd4, 8'h50, 8'hB1, 8'd2,   1'b1, 1'b0, 3'd1, 2'd0},
    {3'd5, 8'h60, 8'hC0, 8'hFF,  1'b1, 1'b0, 3'd2, 2'd0},
    {3'd6, 8'h70, 8'hD0, 8'd1,   1'b0, 1'b1, 3'd2, 2'd1},
    {3'd7, 8'h78, 8'hF0, 8'd0,   1'b0, 1'b0, 3'd1, 2'd0}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_word = 0, cfg_step_dst = 0;
  logic [2:0] cfg_chan = 0, trig_chan = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [CW-1:0] cfg_cnt = 0;
  logic trig_valid = 0, mem_gnt = 0;
  logic [DW-1:0] mem_rdata = 0;
  logic trig_ready, mem_req, mem_we, mem_word, done_valid, irq_valid, err_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [2:0] evt_chan;

  int checks = 0, fails = 0, grants = 0, wait_n = 0, wcnt = 0;
  bit finished = 0;
  logic [7:0] mem [256];
  logic [7:0] m_src [NUM_CH];
  logic [7:0] m_dst [NUM_CH];
  logic [7:0] m_cnt [NUM_CH];
  logic m_word [NUM_CH];
  logic m_sdst [NUM_CH];

  always #2 clk = ~clk;

  evt_mover #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_word(cfg_word), .cfg_step_dst(cfg_step_dst),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_chan(trig_chan),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .irq_valid(irq_valid), .err_valid(err_valid), .evt_chan(evt_chan)
  );

  // memory model: grant decided at the falling edge, completes at the next rising edge
  always @(negedge clk) begin
    mem_gnt = 1'b0;
    if (rst_n && mem_req) begin
      if (wcnt < wait_n) wcnt++;
      else begin
        wcnt = 0;
        mem_gnt = 1'b1;
        grants++;
        if (mem_we) begin
          mem[mem_addr[7:0]] = mem_wdata[7:0];
          if (mem_word) mem[mem_addr[7:0] + 8'd1] = mem_wdata[15:8];
        end else begin
          mem_rdata = mem_word ? {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]}
                               : {8'h00, mem[mem_addr[7:0]]};
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(input int ch, input logic [7:0] s, input logic [7:0] d,
                           input logic [7:0] c, input bit w, input bit sd);
    @(negedge clk);
    cfg_we = 1; cfg_chan = 3'(ch); cfg_src = AW'(s); cfg_dst = AW'(d);
    cfg_cnt = c; cfg_word = w; cfg_step_dst = sd;
    m_src[ch] = s; m_dst[ch] = d; m_cnt[ch] = c; m_word[ch] = w; m_sdst[ch] = sd;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // fire one trigger and judge it against the channel model
  task automatic fire(input int ch);
    int kind = 0, g0, step, seen_ch = 0;
    logic [15:0] exp_data, got;
    bit exp_irq, exp_err;
    exp_irq = (m_cnt[ch] == 8'h00);
    exp_err = !exp_irq && m_word[ch] && (m_src[ch][0] || m_dst[ch][0]);
    exp_data = m_word[ch] ? {mem[m_src[ch] + 8'd1], mem[m_src[ch]]} : {8'h00, mem[m_src[ch]]};
    g0 = grants;
    @(negedge clk);
    trig_valid = 1; trig_chan = 3'(ch);
    @(negedge clk);
    trig_valid = 0;
    check(trig_ready == 1'b0, "R8", int'(trig_ready), 0);
    for (int i = 0; i < 40 && kind == 0; i++) begin
      if (done_valid) kind = 1;
      else if (irq_valid) kind = 2;
      else if (err_valid) kind = 3;
      seen_ch = int'(evt_chan);
      if (kind == 0) @(negedge clk);
    end
    if (exp_irq) begin
      check(kind == 2 && seen_ch == ch, "R5", kind * 16 + seen_ch, 2 * 16 + ch);
      check(grants == g0, "R5", grants - g0, 0);
    end else if (exp_err) begin
      check(kind == 3 && seen_ch == ch, "R6", kind * 16 + seen_ch, 3 * 16 + ch);
      check(grants == g0, "R6", grants - g0, 0);
    end else begin
      check(kind == 1 && seen_ch == ch, "R7", kind * 16 + seen_ch, 1 * 16 + ch);
      check(trig_ready == 1'b1, "R8", int'(trig_ready), 1);
      got = m_word[ch] ? {mem[m_dst[ch] + 8'd1], mem[m_dst[ch]]} : {8'h00, mem[m_dst[ch]]};
      check(got == exp_data, "R2", int'(got), int'(exp_data));
      check(grants - g0 == 2, "R2", grants - g0, 2);
      step = m_word[ch] ? 2 : 1;   // R3 model: one pointer only
      if (m_sdst[ch]) m_dst[ch] = m_dst[ch] + 8'(step);
      else m_src[ch] = m_src[ch] + 8'(step);
      if (m_cnt[ch] != 8'hFF) m_cnt[ch] = m_cnt[ch] - 8'd1;   // R4 model
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(trig_ready == 1 && mem_req == 0, "R1", {trig_ready, mem_req}, 2);
    check({done_valid, irq_valid, err_valid} == 3'b000, "R1", {done_valid, irq_valid, err_valid}, 0);
    rst_n = 1;
    for (int c = 0; c < NUM_CH; c++) begin
      m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; m_word[c] = 0; m_sdst[c] = 0;
    end
    fire(5);   // R1: counters cleared, so the trigger forwards an interrupt
    // R11: all channels set up first, each then serviced without disturbing the others
    for (int v = 0; v < NV; v++)
      configure(int'(VEC[v][33:31]), VEC[v][30:23], VEC[v][22:15], VEC[v][14:7],
                VEC[v][6], VEC[v][5]);
    for (int v = 0; v < NV; v++) begin
      wait_n = int'(VEC[v][1:0]);
      for (int t = 0; t < int'(VEC[v][4:2]); t++) fire(int'(VEC[v][33:31]));
    end
    // R3 and R4: channel 3 (continuous, byte, dst steps) keeps running
    fire(3);
    // R10: configuration write lands in the same cycle as the write grant
    wait_n = 0;
    configure(2, 8'h02, 8'hE0, 8'd4, 1'b0, 1'b0);
    @(negedge clk);
    trig_valid = 1; trig_chan = 3'd2;
    @(negedge clk);
    trig_valid = 0;
    for (int i = 0; i < 20 && !(mem_req && mem_we); i++) @(negedge clk);
    cfg_we = 1; cfg_chan = 3'd2; cfg_src = AW'(8'h08); cfg_dst = AW'(8'hE8);
    cfg_cnt = 8'd1; cfg_word = 0; cfg_step_dst = 0;
    @(negedge clk);
    cfg_we = 0;
    check(done_valid == 1'b1, "R10", int'(done_valid), 1);
    m_src[2] = 8'h08; m_dst[2] = 8'hE8; m_cnt[2] = 8'd1; m_word[2] = 0; m_sdst[2] = 0;
    fire(2);   // R10: copies 0x08 -> 0xE8 from the written setup
    fire(2);   // R10: written counter now exhausted -> interrupt
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule